// File: doc/BRIEF.md
# Radix-4 Booth Partial-Product Generator

This block recodes a signed multiplier into radix-4 Booth digits. For each digit it forms one partial-product row from a signed multiplicand, together with a one-bit correction. The caller adds up the rows and corrections, with row n weighted by 4^n, and the total is the signed product. The adder tree, any pipelining and any accumulation belong to the consumer and are not part of this block.

The multiplier is read as overlapping three-bit windows. The windows are two bits apart, and neighbouring windows share one bit. Below bit 0 there is an implicit zero. A window whose top bit is set, and is not a zero window, makes a negative digit. For a negative digit the row holds the one's complement of the magnitude, and the correction bit supplies the missing +1. A zero digit does not produce a cleared row. It produces an all-ones row with the correction set, so its net value is zero. The correction therefore behaves the same way for every digit that is not positive.

An optional summed product output (parameter `SUM_EN`) adds up the weighted rows inside the block. Its purpose is checking, not the datapath.

Top module: `booth_pp_gen`

## Requirements
- R1: Digit k reads multiplier bits 2k+1, 2k and 2k-1, in that order from top to bottom. Bit -1 is taken as 0.
- R2: Windows 001 and 010 are digit +1. The row is the multiplicand sign-extended by one bit, and the correction is 0.
- R3: Window 011 is digit +2. The row is the multiplicand shifted left by one with a 0 filled in at the bottom, and the correction is 0.
- R4: Windows 101 and 110 are digit -1. The row is the bitwise inverse of the sign-extended multiplicand, and the correction is 1.
- R5: Window 100 is digit -2. The row is the bitwise inverse of the multiplicand shifted left by one, and the correction is 1.
- R6: Windows 000 and 111 are digit 0. Every bit of the row is 1, and the correction is 1.
- R7: When `SUM_EN` is 1, `prod_o` equals the signed product of `mult_i` and `mcand_i`, held as MLT_W+MCD_W bits in two's complement.
- R8: Take each row sign-extended to the product width, add its correction, and shift left by 2n. The sum of these terms over all rows equals the signed product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mult_i | input | MLT_W (12) | Signed multiplier to be recoded |
| mcand_i | input | MCD_W (13) | Signed multiplicand |
| rows_o | output | (MLT_W/2)*(MCD_W+1) (84) | Partial-product rows. Row k is at bits [k*14 +: 14] |
| corr_o | output | MLT_W/2 (6) | Correction bit for each row. Bit k belongs to row k |
| prod_o | output | MLT_W+MCD_W (25) | Summed signed product. Tied to zero when SUM_EN is 0 |

## Verification
The bench uses the default widths, 12 by 13 bits, with `SUM_EN` set to 1. At these widths the full multiplier range of 4096 values can be swept against every chosen multiplicand. The sweep reaches every window code in every digit position, including the top digit, which carries the multiplier's sign. The multiplicands include the most negative value, -4096, and its neighbours. With -4096, the doubled digits fill the 14-bit row completely, so R3, R5 and R8 are tested at their extremes.

// File: rtl/booth_pp_gen.sv
module booth_pp_gen #(
  parameter int MLT_W  = 12,
  parameter int MCD_W  = 13,
  parameter bit SUM_EN = 1'b1
) (
  input  logic [MLT_W-1:0]                   mult_i,
  input  logic [MCD_W-1:0]                   mcand_i,
  output logic [(MLT_W/2)*(MCD_W+1)-1:0]     rows_o,
  output logic [MLT_W/2-1:0]                 corr_o,
  output logic [MLT_W+MCD_W-1:0]             prod_o
);
  localparam int ROWS   = MLT_W / 2;
  localparam int ROW_W  = MCD_W + 1;
  localparam int PROD_W = MLT_W + MCD_W;

  logic [MLT_W:0]   mx;
  logic [ROW_W-1:0] single_m;
  logic [ROW_W-1:0] double_m;

  assign mx       = {mult_i, 1'b0};
  assign single_m = {mcand_i[MCD_W-1], mcand_i};
  assign double_m = {mcand_i, 1'b0};

  for (genvar k = 0; k < ROWS; k++) begin : g_dig
    logic [2:0]       win;
    logic             is_zero;
    logic             is_dbl;
    logic             is_neg;
    logic [ROW_W-1:0] mag;

    assign win     = mx[2*k+2 -: 3];
    assign is_zero = (win == 3'b000) || (win == 3'b111);
    assign is_dbl  = (win == 3'b011) || (win == 3'b100);
    assign is_neg  = win[2] & ~is_zero;
    assign mag     = is_dbl ? double_m : single_m;

    assign rows_o[k*ROW_W +: ROW_W] = is_zero ? {ROW_W{1'b1}} : (is_neg ? ~mag : mag);
    assign corr_o[k]                = is_neg | is_zero;
  end

  if (SUM_EN) begin : g_sum
    logic [PROD_W-1:0] acc;
    always_comb begin
      logic [ROW_W-1:0]  r;
      logic [PROD_W-1:0] term;
      acc = '0;
      for (int k = 0; k < ROWS; k++) begin
        r    = rows_o[k*ROW_W +: ROW_W];
        term = {{(PROD_W-ROW_W){r[ROW_W-1]}}, r} + PROD_W'(corr_o[k]);
        acc  = acc + (term << (2*k));
      end
    end
    assign prod_o = acc;
  end else begin : g_nosum
    assign prod_o = '0;
  end
endmodule

// File: rtl/booth_pp_gen_chk.sv
module booth_pp_gen_chk #(
  parameter int MLT_W  = 12,
  parameter int MCD_W  = 13,
  parameter bit SUM_EN = 1'b1
) (
  input logic [MLT_W-1:0]               mult_i,
  input logic [MCD_W-1:0]               mcand_i,
  input logic [(MLT_W/2)*(MCD_W+1)-1:0] rows_o,
  input logic [MLT_W/2-1:0]             corr_o,
  input logic [MLT_W+MCD_W-1:0]         prod_o
);
  localparam int ROWS   = MLT_W / 2;
  localparam int ROW_W  = MCD_W + 1;
  localparam int PROD_W = MLT_W + MCD_W;

  logic [MLT_W:0] ext;
  assign ext = {mult_i, 1'b0};

  for (genvar k = 0; k < ROWS; k++) begin : g_chk
    always_comb begin
      logic [2:0]       w;
      logic [ROW_W-1:0] r;
      w = ext[2*k+2 -: 3];
      r = rows_o[k*ROW_W +: ROW_W];
      if (!$isunknown({mult_i, mcand_i})) begin
        if (w == 3'b000 || w == 3'b111)
          a_r6_zero_row: assert (&r && corr_o[k]) else $error("R6 zero digit row %0d", k);
        if (w[2])
          a_r4_neg_corr: assert (corr_o[k]) else $error("R4 negative digit lacks correction, row %0d", k);
        if (w == 3'b001 || w == 3'b010 || w == 3'b011)
          a_r2_pos_nocorr: assert (!corr_o[k]) else $error("R2 positive digit has correction, row %0d", k);
        if (w == 3'b011)
          a_r3_double_row: assert (r == {mcand_i, 1'b0}) else $error("R3 doubled row %0d", k);
        if (w == 3'b100)
          a_r5_negdouble_row: assert (r == ~{mcand_i, 1'b0}) else $error("R5 row %0d", k);
      end
    end
  end

  if (SUM_EN) begin : g_prod
    always_comb begin
      logic signed [PROD_W-1:0] ref_p;
      ref_p = PROD_W'($signed(mult_i)) * PROD_W'($signed(mcand_i));
      if (!$isunknown({mult_i, mcand_i}))
        a_r7_product: assert (prod_o == ref_p) else $error("R7 product mismatch");
    end
  end
endmodule

bind booth_pp_gen booth_pp_gen_chk #(.MLT_W(MLT_W), .MCD_W(MCD_W), .SUM_EN(SUM_EN)) chk_i (
  .mult_i(mult_i), .mcand_i(mcand_i), .rows_o(rows_o), .corr_o(corr_o), .prod_o(prod_o)
);

// File: tb/booth_pp_gen_tb.sv
`timescale 1ns/1ps
module booth_pp_gen_tb_top;
  localparam int MLT_W  = 12;
  localparam int MCD_W  = 13;
  localparam int ROWS   = MLT_W / 2;
  localparam int ROW_W  = MCD_W + 1;
  localparam int PROD_W = MLT_W + MCD_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [MLT_W-1:0]      mult;
  logic [MCD_W-1:0]      mcand;
  logic [ROWS*ROW_W-1:0] rows;
  logic [ROWS-1:0]       corr;
  logic [PROD_W-1:0]     prod;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int cyc = 0;

  booth_pp_gen #(.MLT_W(MLT_W), .MCD_W(MCD_W), .SUM_EN(1'b1)) dut_i (
    .mult_i(mult), .mcand_i(mcand), .rows_o(rows), .corr_o(corr), .prod_o(prod)
  );

  function automatic int digit_of(input logic [MLT_W-1:0] m, input int k);
    logic [MLT_W:0] e;
    logic [2:0] w;
    e = {m, 1'b0};
    w = e[2*k+2 -: 3];
    return -2*int'(w[2]) + int'(w[1]) + int'(w[0]);
  endfunction

  function automatic logic [ROW_W:0] exp_row(input logic [MLT_W-1:0] m,
                                             input logic [MCD_W-1:0] b, input int k);
    int d;
    int v;
    logic [31:0] t;
    d = digit_of(m, k);
    if (d == 0) return {1'b1, {ROW_W{1'b1}}};
    if (d > 0) begin
      v = d * int'($signed(b));
      t = v;
      return {1'b0, t[ROW_W-1:0]};
    end
    v = -d * int'($signed(b));
    t = v;
    return {1'b1, ~t[ROW_W-1:0]};
  endfunction

  function automatic string tag_of(input int d, input int k);
    if (k == 0) return "R1";
    case (d)
      1: return "R2";
      2: return "R3";
      -1: return "R4";
      -2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check_now();
    longint sp;
    longint ws;
    logic [ROW_W:0] e;
    logic [PROD_W-1:0] ep;
    sp = longint'($signed(mult)) * longint'($signed(mcand));
    ep = sp[PROD_W-1:0];
    for (int k = 0; k < ROWS; k++) begin
      e = exp_row(mult, mcand, k);
      n_run++;
      if ({corr[k], rows[k*ROW_W +: ROW_W]} != e) begin
        n_fail++;
        $display("FAIL %s m=%h b=%h row%0d got corr=%b row=%h exp corr=%b row=%h",
                 tag_of(digit_of(mult, k), k), mult, mcand, k,
                 corr[k], rows[k*ROW_W +: ROW_W], e[ROW_W], e[ROW_W-1:0]);
      end
    end
    n_run++;
    if (prod != ep) begin
      n_fail++;
      $display("FAIL R7 m=%h b=%h got %h exp %h", mult, mcand, prod, ep);
    end
    ws = 0;
    for (int k = 0; k < ROWS; k++)
      ws += (longint'($signed(rows[k*ROW_W +: ROW_W])) + longint'(corr[k])) <<< (2*k);
    n_run++;
    if (ws != sp) begin
      n_fail++;
      $display("FAIL R8 m=%h b=%h got %0d exp %0d", mult, mcand, ws, sp);
    end
  endtask

  task automatic apply(input logic [MLT_W-1:0] m, input logic [MCD_W-1:0] b);
    @(negedge clk);
    mult = m;
    mcand = b;
    @(posedge clk);
    #1;
    check_now();
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired got cycle %0d exp below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [MCD_W-1:0] bset [8];
    void'($urandom(32'h5eed_b00c));
    mult = '0;
    mcand = '0;
    bset[0] = 13'h1000;
    bset[1] = 13'h1001;
    bset[2] = 13'h1FFF;
    bset[3] = 13'h0000;
    bset[4] = 13'h0001;
    bset[5] = 13'h0FFF;
    bset[6] = 13'h0800;
    bset[7] = 13'h0555;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R6 reset-state: all-zero inputs give all-ones rows with corrections set
    #1;
    n_run++;
    if (!(&rows) || !(&corr) || prod != '0) begin
      n_fail++;
      $display("FAIL R6 idle got rows=%h corr=%b exp all ones", rows, corr);
    end
    // R1 digit 0 with implicit zero below bit 0: multiplier 1 -> +1
    apply(12'h001, 13'h0123);
    apply(12'hFFF, 13'h1000);
    apply(12'h800, 13'h1000);
    for (int j = 0; j < 8; j++)
      for (int m = 0; m < (1 << MLT_W); m++)
        apply(MLT_W'(m), bset[j]);
    for (int j = 0; j < 14; j++) begin
      logic [MCD_W-1:0] rb;
      rb = MCD_W'($urandom);
      for (int m = 0; m < (1 << MLT_W); m++)
        apply(MLT_W'(m), rb);
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule